// File: doc/BRIEF.md
# Page-Table Refill Engine for a Software-Managed TLB

This block services a TLB miss in hardware. A miss sets the `start_i` strobe and supplies the faulting virtual address, the page-table base and the cause code the miss would raise. The engine first forms the virtual address of the page-table entry that covers the faulting page. It then translates that address through a non-walking lookup port into the TLB. This lookup is a privilege-0 read and never starts a walk of its own. Next it reads the 32-bit entry from memory. Finally it writes a decoded entry into one of four rotating refill ways.

A successful install also loads the faulting-address register. A failure in either the lookup or the memory read ends the refill without touching any state. In that case the engine reports the original miss cause, so the core can take the ordinary miss exception.

A probe variant runs the same sequence but writes nothing. The would-be entry is presented on the entry outputs in the completion cycle. This serves debug-style translation queries.

Top module: `pt_refill_engine`

## Requirements
- R1: The address driven on `lk_vaddr_o` while `lk_valid_o` is high equals `(pt_base | (miss_vaddr >> 10))` with bits [1:0] forced to zero, using the base and address captured at start.
- R2: If the lookup answers with `lk_hit_i` low, the engine pulses `fail_o` with `fail_cause_o` equal to the captured miss cause. It issues no memory read, no `tlb_we_o` and no `excvaddr_we_o`.
- R3: If the memory read answers with `mem_err_i` high, the engine pulses `fail_o` with the captured miss cause and writes neither the TLB nor the faulting-address register.
- R4: The memory read address `mem_addr_o` equals the `lk_paddr_i` returned by a hitting lookup.
- R5: The entry ring `tlb_ring_o` is bits [5:4] of the fetched entry. `tlb_asid_o` is byte k (bits 8k+7:8k) of `ring_asid_i`, where k is that ring.
- R6: `tlb_ppn_o` is bits [31:12] of the fetched entry and `tlb_attr_o` is bits [3:0]. `tlb_index_o` is miss-address bits [12+IDX_W-1:12] and `tlb_vpn_o` is miss-address bits [31:12+IDX_W].
- R7: The refill way is chosen by incrementing a 2-bit counter and then using its new value. The counter is 0 after reset, so successive installs use ways 1, 2, 3, 0, 1. Failed and probe refills leave it unchanged.
- R8: In the cycle an entry is installed (`tlb_we_o` high), `excvaddr_we_o` is also high and `excvaddr_o` carries the captured miss address. `done_o` follows in the next cycle.
- R9: A refill started with `probe_i` high ends with `done_o` and valid entry outputs. During it, `tlb_we_o` and `excvaddr_we_o` stay low.
- R10: `busy_o` rises the cycle after an accepted start and stays high through the `done_o` or `fail_o` cycle, then falls. A `start_i` while busy is ignored, along with any change of the request inputs.
- R11: After reset the engine is idle: `busy_o`, `done_o`, `fail_o`, `tlb_we_o`, `lk_valid_o` and `mem_req_o` are low.
- R12: `done_o` and `fail_o` are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a refill (taken when idle) |
| probe_i | input | 1 | Probe only: compute the entry, write nothing |
| miss_vaddr_i | input | 32 | Faulting virtual address |
| miss_cause_i | input | CAUSE_W | Cause code reported if the refill fails |
| pt_base_i | input | 32 | Page-table base register |
| ring_asid_i | input | 32 | Four ASID bytes, byte k for ring k |
| lk_valid_o | output | 1 | Lookup request, held until `lk_done_i` |
| lk_vaddr_o | output | 32 | Virtual address of the page-table entry |
| lk_done_i | input | 1 | Lookup answer strobe |
| lk_hit_i | input | 1 | Lookup found a single usable entry |
| lk_paddr_i | input | 32 | Physical address of the page-table entry |
| mem_req_o | output | 1 | Memory read request, held until `mem_ack_i` |
| mem_addr_o | output | 32 | Read address |
| mem_ack_i | input | 1 | Read answer strobe |
| mem_err_i | input | 1 | Bus error on the read |
| mem_rdata_i | input | 32 | Fetched page-table entry |
| tlb_we_o | output | 1 | TLB entry write strobe |
| tlb_way_o | output | 2 | Refill way |
| tlb_index_o | output | IDX_W | Entry index within the way |
| tlb_vpn_o | output | 32-12-IDX_W | Virtual page tag |
| tlb_ppn_o | output | 20 | Physical page number |
| tlb_attr_o | output | 4 | Attribute field |
| tlb_ring_o | output | 2 | Ring of the entry |
| tlb_asid_o | output | 8 | ASID written with the entry |
| excvaddr_we_o | output | 1 | Faulting-address register write |
| excvaddr_o | output | 32 | Value for that register |
| busy_o | output | 1 | Refill in progress |
| done_o | output | 1 | Refill completed (pulse) |
| fail_o | output | 1 | Refill failed (pulse) |
| fail_cause_o | output | CAUSE_W | Cause to raise on failure |

## Verification
The bench runs enough installs to walk the way counter past its wrap. A design that used the counter before incrementing it would start at way 0, and one that counted failed or probe refills would skip a way; both are caught. A lookup miss and a bus error are each injected between installs. A design that wrote the TLB on a failure, or reported a cause other than the original miss cause, is caught that way. The entry's ring and attribute are chosen to expose any bit slip in the [5:4] and [3:0] fields or in the ASID byte selection. A refill is also re-requested with a different address while busy, so an engine that restarted or re-latched its request would install the wrong address.

// File: rtl/pt_refill_pkg.sv
package pt_refill_pkg;

    localparam int VA_W       = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int PTE_SHIFT  = 10;
    localparam int PPN_W      = VA_W - PAGE_SHIFT;
    localparam int ATTR_W     = 4;
    localparam int RING_W     = 2;
    localparam int ASID_W     = 8;
    localparam int RING_LSB   = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XLATE,
        ST_READ,
        ST_WRITE,
        ST_DONE,
        ST_FAIL
    } refill_state_t;

    typedef struct packed {
        logic [PPN_W-1:0]  ppn;
        logic [RING_W-1:0] ring;
        logic [ATTR_W-1:0] attr;
    } pte_fields_t;

    // Page-table entry address: base merged with the scaled faulting address, word aligned.
    function automatic logic [VA_W-1:0] pte_address(input logic [VA_W-1:0] base,
                                                    input logic [VA_W-1:0] va);
        logic [VA_W-1:0] a;
        a = base | (va >> PTE_SHIFT);
        a[1:0] = 2'b00;
        return a;
    endfunction

    function automatic pte_fields_t split_pte(input logic [VA_W-1:0] pte);
        pte_fields_t f;
        f.ppn  = pte[VA_W-1:PAGE_SHIFT];
        f.ring = pte[RING_LSB +: RING_W];
        f.attr = pte[ATTR_W-1:0];
        return f;
    endfunction

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen
    import pt_refill_pkg::*;
(
    input  logic [VA_W-1:0] base_i,
    input  logic [VA_W-1:0] vaddr_i,
    output logic [VA_W-1:0] pte_va_o
);
    always_comb pte_va_o = pte_address(base_i, vaddr_i);
endmodule

// File: rtl/pte_decoder.sv
module pte_decoder
    import pt_refill_pkg::*;
#(
    parameter int RINGS = 4
) (
    input  logic [VA_W-1:0]         pte_i,
    input  logic [RINGS*ASID_W-1:0] ring_asid_i,
    output pte_fields_t             fields_o,
    output logic [ASID_W-1:0]       asid_o
);
    logic [ASID_W-1:0] asid_tab [RINGS];

    generate
        for (genvar k = 0; k < RINGS; k++) begin : g_ring
            assign asid_tab[k] = ring_asid_i[k*ASID_W +: ASID_W];
        end
    endgenerate

    always_comb begin
        fields_o = split_pte(pte_i);
        asid_o   = asid_tab[fields_o.ring];
    end
endmodule

// File: rtl/refill_way_ctr.sv
module refill_way_ctr #(
    parameter int WAYS  = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_i,
    output logic [WAY_W-1:0] way_o
);
    logic [WAY_W-1:0] cnt_q;

    // The way used is the value after increment.
    always_comb way_o = cnt_q + WAY_W'(1);

    always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (adv_i) cnt_q <= way_o;
    end
endmodule

// File: rtl/pt_refill_engine.sv
module pt_refill_engine
    import pt_refill_pkg::*;
#(
    parameter int IDX_W   = 2,
    parameter int CAUSE_W = 6,
    localparam int WAYS   = 4,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int VPN_W  = VA_W - PAGE_SHIFT - IDX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               probe_i,
    input  logic [31:0]        miss_vaddr_i,
    input  logic [CAUSE_W-1:0] miss_cause_i,
    input  logic [31:0]        pt_base_i,
    input  logic [31:0]        ring_asid_i,
    output logic               lk_valid_o,
    output logic [31:0]        lk_vaddr_o,
    input  logic               lk_done_i,
    input  logic               lk_hit_i,
    input  logic [31:0]        lk_paddr_i,
    output logic               mem_req_o,
    output logic [31:0]        mem_addr_o,
    input  logic               mem_ack_i,
    input  logic               mem_err_i,
    input  logic [31:0]        mem_rdata_i,
    output logic               tlb_we_o,
    output logic [WAY_W-1:0]   tlb_way_o,
    output logic [IDX_W-1:0]   tlb_index_o,
    output logic [VPN_W-1:0]   tlb_vpn_o,
    output logic [19:0]        tlb_ppn_o,
    output logic [3:0]         tlb_attr_o,
    output logic [1:0]         tlb_ring_o,
    output logic [7:0]         tlb_asid_o,
    output logic               excvaddr_we_o,
    output logic [31:0]        excvaddr_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               fail_o,
    output logic [CAUSE_W-1:0] fail_cause_o
);
    refill_state_t       state_q, state_d;
    logic [VA_W-1:0]     va_q, base_q, pa_q, pte_q;
    logic [CAUSE_W-1:0]  cause_q;
    logic                probe_q;
    logic                accept;
    logic                install;
    pte_fields_t         fields;
    logic [ASID_W-1:0]   asid;

    assign accept  = start_i && (state_q == ST_IDLE);
    assign install = (state_q == ST_WRITE) && !probe_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_XLATE;
            ST_XLATE: if (lk_done_i) state_d = lk_hit_i ? ST_READ : ST_FAIL;
            ST_READ:  if (mem_ack_i) state_d = mem_err_i ? ST_FAIL : ST_WRITE;
            ST_WRITE: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            ST_FAIL:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            va_q    <= '0;
            base_q  <= '0;
            pa_q    <= '0;
            pte_q   <= '0;
            cause_q <= '0;
            probe_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                va_q    <= miss_vaddr_i;
                base_q  <= pt_base_i;
                cause_q <= miss_cause_i;
                probe_q <= probe_i;
            end
            if (state_q == ST_XLATE && lk_done_i && lk_hit_i) pa_q <= lk_paddr_i;
            if (state_q == ST_READ && mem_ack_i && !mem_err_i) pte_q <= mem_rdata_i;
        end
    end

    pt_addr_gen u_addr (
        .base_i  (base_q),
        .vaddr_i (va_q),
        .pte_va_o(lk_vaddr_o)
    );

    pte_decoder #(.RINGS(4)) u_dec (
        .pte_i      (pte_q),
        .ring_asid_i(ring_asid_i),
        .fields_o   (fields),
        .asid_o     (asid)
    );

    refill_way_ctr #(.WAYS(WAYS)) u_way (
        .clk  (clk),
        .rst  (rst),
        .adv_i(install),
        .way_o(tlb_way_o)
    );

    assign lk_valid_o    = (state_q == ST_XLATE);
    assign mem_req_o     = (state_q == ST_READ);
    assign mem_addr_o    = pa_q;
    assign tlb_we_o      = install;
    assign tlb_index_o   = va_q[PAGE_SHIFT +: IDX_W];
    assign tlb_vpn_o     = va_q[VA_W-1:PAGE_SHIFT+IDX_W];
    assign tlb_ppn_o     = fields.ppn;
    assign tlb_attr_o    = fields.attr;
    assign tlb_ring_o    = fields.ring;
    assign tlb_asid_o    = asid;
    assign excvaddr_we_o = install;
    assign excvaddr_o    = va_q;
    assign busy_o        = (state_q != ST_IDLE);
    assign done_o        = (state_q == ST_DONE);
    assign fail_o        = (state_q == ST_FAIL);
    assign fail_cause_o  = cause_q;
endmodule

// File: rtl/pt_refill_checker.sv
module pt_refill_checker (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic        probe_i,
    input logic [31:0] miss_vaddr_i,
    input logic        lk_valid_o,
    input logic [31:0] lk_vaddr_o,
    input logic        mem_req_o,
    input logic        tlb_we_o,
    input logic [1:0]  tlb_way_o,
    input logic        excvaddr_we_o,
    input logic [31:0] excvaddr_o,
    input logic        busy_o,
    input logic        done_o,
    input logic        fail_o
);
    logic [1:0]  last_way;
    logic [31:0] req_va;
    logic        req_probe;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_way  <= '0;
            req_va    <= '0;
            req_probe <= 1'b0;
        end else begin
            if (tlb_we_o) last_way <= tlb_way_o;
            if (start_i && !busy_o) begin
                req_va    <= miss_vaddr_i;
                req_probe <= probe_i;
            end
        end
    end

    AST_PTE_ALIGNED: assert property (@(posedge clk) disable iff (rst) lk_valid_o |-> lk_vaddr_o[1:0] == 2'b00); // R1
    AST_WAY_ROTATE:  assert property (@(posedge clk) disable iff (rst) tlb_we_o |-> tlb_way_o == last_way + 2'd1); // R7
    AST_EXCVA_LOAD:  assert property (@(posedge clk) disable iff (rst) tlb_we_o |-> excvaddr_we_o && excvaddr_o == req_va); // R8
    AST_DONE_AFTER:  assert property (@(posedge clk) disable iff (rst) tlb_we_o |=> done_o); // R8
    AST_PROBE_QUIET: assert property (@(posedge clk) disable iff (rst) (busy_o && req_probe) |-> !tlb_we_o && !excvaddr_we_o); // R9
    AST_END_IDLE:    assert property (@(posedge clk) disable iff (rst) (done_o || fail_o) |=> !busy_o); // R10
    AST_ONE_PORT:    assert property (@(posedge clk) disable iff (rst) mem_req_o |-> !lk_valid_o); // R4
    AST_EXCLUSIVE:   assert property (@(posedge clk) disable iff (rst) !(done_o && fail_o)); // R12
    AST_PULSE:       assert property (@(posedge clk) disable iff (rst) (done_o || fail_o) |=> !done_o && !fail_o); // R12
endmodule

bind pt_refill_engine pt_refill_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .probe_i      (probe_i),
    .miss_vaddr_i (miss_vaddr_i),
    .lk_valid_o   (lk_valid_o),
    .lk_vaddr_o   (lk_vaddr_o),
    .mem_req_o    (mem_req_o),
    .tlb_we_o     (tlb_we_o),
    .tlb_way_o    (tlb_way_o),
    .excvaddr_we_o(excvaddr_we_o),
    .excvaddr_o   (excvaddr_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .fail_o       (fail_o)
);

// File: tb/pt_refill_engine_test.sv
module pt_refill_engine_test;
    localparam int IDX_W = 2;
    localparam int CW    = 6;

    logic clk = 0, rst = 1;
    always #5 clk = ~clk;

    logic start_i = 0, probe_i = 0;
    logic [31:0] miss_vaddr_i = 0, pt_base_i = 0;
    logic [31:0] ring_asid_i = 32'h4433_2211;
    logic [CW-1:0] miss_cause_i = 0;
    logic lk_valid_o, lk_done_i, lk_hit_i;
    logic [31:0] lk_vaddr_o, lk_paddr_i;
    logic mem_req_o, mem_ack_i, mem_err_i;
    logic [31:0] mem_addr_o, mem_rdata_i;
    logic tlb_we_o, excvaddr_we_o, busy_o, done_o, fail_o;
    logic [1:0] tlb_way_o, tlb_ring_o;
    logic [IDX_W-1:0] tlb_index_o;
    logic [31-12-IDX_W:0] tlb_vpn_o;
    logic [19:0] tlb_ppn_o;
    logic [3:0] tlb_attr_o;
    logic [7:0] tlb_asid_o;
    logic [31:0] excvaddr_o;
    logic [CW-1:0] fail_cause_o;

    logic        env_hit = 1, env_err = 0;
    logic [31:0] env_pa = 0, env_pte = 0;

    int vectors = 0, miscompares = 0;
    logic [1:0] exp_cnt = 0;

    pt_refill_engine #(.IDX_W(IDX_W), .CAUSE_W(CW)) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .probe_i(probe_i),
        .miss_vaddr_i(miss_vaddr_i), .miss_cause_i(miss_cause_i),
        .pt_base_i(pt_base_i), .ring_asid_i(ring_asid_i),
        .lk_valid_o(lk_valid_o), .lk_vaddr_o(lk_vaddr_o), .lk_done_i(lk_done_i),
        .lk_hit_i(lk_hit_i), .lk_paddr_i(lk_paddr_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
        .mem_err_i(mem_err_i), .mem_rdata_i(mem_rdata_i),
        .tlb_we_o(tlb_we_o), .tlb_way_o(tlb_way_o), .tlb_index_o(tlb_index_o),
        .tlb_vpn_o(tlb_vpn_o), .tlb_ppn_o(tlb_ppn_o), .tlb_attr_o(tlb_attr_o),
        .tlb_ring_o(tlb_ring_o), .tlb_asid_o(tlb_asid_o),
        .excvaddr_we_o(excvaddr_we_o), .excvaddr_o(excvaddr_o),
        .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o), .fail_cause_o(fail_cause_o)
    );

    // Responders: answer one cycle after a request appears.
    always_ff @(posedge clk) begin
        if (rst) begin
            lk_done_i <= 1'b0;
            mem_ack_i <= 1'b0;
        end else begin
            lk_done_i <= lk_valid_o && !lk_done_i;
            mem_ack_i <= mem_req_o && !mem_ack_i;
        end
    end
    assign lk_hit_i    = env_hit;
    assign lk_paddr_i  = env_pa;
    assign mem_err_i   = env_err;
    assign mem_rdata_i = env_pte;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_refill(input logic [31:0] va, input logic [31:0] base,
                              input logic [CW-1:0] cause, input logic probe,
                              input logic hit, input logic [31:0] pa,
                              input logic err, input logic [31:0] pte, input logic poke);
        logic busy_ok = 1, fin = 0, saw_done = 0, saw_fail = 0, saw_mem = 0;
        logic saw_we = 0, saw_exc = 0;
        logic [31:0] seen_lk = 0, seen_mem = 0, seen_exc = 0;
        logic [CW-1:0] seen_cause = 0;
        logic [1:0] seen_way = 0, ring;
        logic [IDX_W-1:0] seen_idx = 0;
        logic [31-12-IDX_W:0] seen_vpn = 0;
        logic [19:0] seen_ppn = 0;
        logic [3:0] seen_attr = 0;
        logic [1:0] seen_ring = 0;
        logic [7:0] seen_asid = 0;
        logic success;
        env_hit = hit; env_pa = pa; env_err = err; env_pte = pte;
        @(negedge clk);
        miss_vaddr_i = va; pt_base_i = base; miss_cause_i = cause; probe_i = probe; start_i = 1;
        @(negedge clk);
        start_i = 0;
        for (int c = 0; c < 40; c++) begin
            if (c > 0) @(negedge clk);
            if (!busy_o) busy_ok = 0;
            if (lk_valid_o) seen_lk = lk_vaddr_o;
            if (mem_req_o) begin saw_mem = 1; seen_mem = mem_addr_o; end
            if (tlb_we_o) begin saw_we = 1; seen_way = tlb_way_o; end
            if (excvaddr_we_o) begin saw_exc = 1; seen_exc = excvaddr_o; end
            if (poke && c == 0) begin
                start_i = 1; miss_vaddr_i = ~va; pt_base_i = ~base; probe_i = ~probe;
            end else if (poke && c == 1) start_i = 0;
            if (done_o || fail_o) begin
                fin = 1; saw_done = done_o; saw_fail = fail_o; seen_cause = fail_cause_o;
                seen_idx = tlb_index_o; seen_vpn = tlb_vpn_o; seen_ppn = tlb_ppn_o;
                seen_attr = tlb_attr_o; seen_ring = tlb_ring_o; seen_asid = tlb_asid_o;
                break;
            end
        end
        start_i = 0;
        check("R10 finished", {31'd0, fin}, 32'd1);
        check("R10 busy held", {31'd0, busy_ok}, 32'd1);
        check("R12 done/fail exclusive", {31'd0, saw_done & saw_fail}, 32'd0);
        check("R1 pte vaddr", seen_lk, ((base | (va >> 10)) & 32'hFFFF_FFFC));
        success = hit && !err;
        check("R2/R3 outcome done", {31'd0, saw_done}, {31'd0, success});
        if (!success) begin
            check("R2/R3 fail cause", {26'd0, seen_cause}, {26'd0, cause});
            check("R2/R3 no tlb write", {31'd0, saw_we}, 32'd0);
            check("R2/R3 no excvaddr write", {31'd0, saw_exc}, 32'd0);
            if (!hit) check("R2 no mem read", {31'd0, saw_mem}, 32'd0);
        end else begin
            check("R4 mem addr", seen_mem, pa);
            ring = pte[5:4];
            check("R5 ring", {30'd0, seen_ring}, {30'd0, ring});
            check("R5 asid", {24'd0, seen_asid}, {24'd0, ring_asid_i[8*ring +: 8]});
            check("R6 ppn", {12'd0, seen_ppn}, {12'd0, pte[31:12]});
            check("R6 attr", {28'd0, seen_attr}, {28'd0, pte[3:0]});
            check("R6 index", {30'd0, seen_idx}, {30'd0, va[13:12]});
            check("R6 vpn", {14'd0, seen_vpn}, {14'd0, va[31:14]});
            if (probe) begin
                check("R9 probe no tlb write", {31'd0, saw_we}, 32'd0);
                check("R9 probe no excvaddr", {31'd0, saw_exc}, 32'd0);
            end else begin
                exp_cnt = exp_cnt + 2'd1;
                check("R7 way", {30'd0, seen_way}, {30'd0, exp_cnt});
                check("R8 excvaddr we", {31'd0, saw_exc}, 32'd1);
                check("R8 excvaddr value", seen_exc, va);
            end
        end
        @(negedge clk);
        check("R10 idle after end", {31'd0, busy_o}, 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R11 busy", {31'd0, busy_o}, 32'd0);
        check("R11 done/fail", {30'd0, done_o, fail_o}, 32'd0);
        check("R11 requests", {29'd0, tlb_we_o, lk_valid_o, mem_req_o}, 32'd0);
    endtask

    initial begin
        #(10 * 5000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        // R1 R5 R6 R7 R8: plain install, ring 2, first way 1
        run_refill(32'h1234_5678, 32'hC000_0000, 6'd16, 0, 1, 32'h0800_1000, 0, 32'hABCD_E025, 0);
        // R2: lookup miss
        run_refill(32'h0004_1000, 32'h8000_0000, 6'd24, 0, 0, 32'h0, 0, 32'h0, 0);
        // R3: bus error
        run_refill(32'h7FFF_F000, 32'h8000_0000, 6'd16, 0, 1, 32'h0000_2000, 1, 32'hFFFF_FFFF, 0);
        // R9: probe
        run_refill(32'hDEAD_B000, 32'h4000_0000, 6'd24, 1, 1, 32'h0000_3004, 0, 32'h1357_9F3A, 0);
        // R7: rotation continues 2, 3, 0, with rings 0, 1, 3
        run_refill(32'h0000_3000, 32'hFFC0_0000, 6'd16, 0, 1, 32'h0000_4000, 0, 32'h0000_1007, 0);
        run_refill(32'h8765_4321, 32'hFFC0_0000, 6'd16, 0, 1, 32'h0000_5008, 0, 32'h2222_201C, 0);
        run_refill(32'hFFFF_FFFF, 32'h0000_0000, 6'd16, 0, 1, 32'h0000_600C, 0, 32'hFFFF_F03F, 0);
        // R10: restart while busy is ignored; way wraps back to 1
        run_refill(32'h2468_A000, 32'hA000_0000, 6'd16, 0, 1, 32'h0000_7010, 0, 32'h0BAD_0011, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule